// File: doc/BRIEF.md
# Laned Vector Register Bank

This block holds a bank of 128-bit vector registers. Each register can be accessed as a whole, as one of two 64-bit halves, or as one of four 32-bit words. An execution datapath uses it as the register file of a vector unit. Two read ports return views of any register at any lane granularity, and one write port updates a register.

The write port has three modes. A quadword write replaces the whole register. A lane insert replaces only the selected 64-bit or 32-bit lane. A scalar write places a 32-bit or 64-bit value at the bottom of the register and clears every bit above it.

Reads are combinational. A write takes effect at the rising clock edge. A lane index that does not fit the chosen lane size, or a reserved encoding, raises an error flag. A flagged write is dropped.

Top module: `vreg_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 128 bits of every register.
- R2: In quadword write mode (`wr_mode` = 2'b00), `wr_data[63:0]` becomes the low half and `wr_data[127:64]` becomes the high half. The change becomes visible after the rising edge, so a read in the same cycle as the write returns the old contents.
- R3: A read with size 2'b01 (64-bit lane) returns lane `L` (bits `64L+63:64L`, with L = 0 or 1) zero-extended to 128 bits. A read with size 2'b10 returns the whole register.
- R4: A read with size 2'b00 (32-bit lane) returns word `L` (bits `32L+31:32L`, with L = 0 to 3) zero-extended to 128 bits.
- R5: In lane insert mode (`wr_mode` = 2'b01) with size 2'b01, only 64-bit lane `wr_lane[0]` takes `wr_data[63:0]`. The other half is left unchanged.
- R6: In lane insert mode with size 2'b00, only word `wr_lane` takes `wr_data[31:0]`. The other three words are left unchanged.
- R7: In scalar mode (`wr_mode` = 2'b10) with size 2'b01, the register becomes `{64'b0, wr_data[63:0]}`. `wr_lane` is ignored.
- R8: In scalar mode with size 2'b00, the register becomes `{96'b0, wr_data[31:0]}`.
- R9: `wr_err` is high during a write in any of these cases: mode 2'b11, insert with size 2'b10 or 2'b11, scalar with size 2'b10 or 2'b11, or a 64-bit insert with `wr_lane[1]` set. The flagged write leaves the register unchanged.
- R10: A read port raises its error flag and returns zero for size 2'b11, or for size 2'b01 with lane bit 1 set.
- R11: The two read ports are independent. Each returns its own view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ra_idx | input | 5 | Read port A register index |
| ra_size | input | 2 | Read port A lane size (00 32-bit, 01 64-bit, 10 128-bit) |
| ra_lane | input | 2 | Read port A lane index |
| ra_data | output | 128 | Read port A data, zero-extended |
| ra_err | output | 1 | Read port A lane/size error |
| rb_idx | input | 5 | Read port B register index |
| rb_size | input | 2 | Read port B lane size |
| rb_lane | input | 2 | Read port B lane index |
| rb_data | output | 128 | Read port B data, zero-extended |
| rb_err | output | 1 | Read port B lane/size error |
| we | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_mode | input | 2 | 00 quadword, 01 lane insert, 10 scalar |
| wr_size | input | 2 | Lane size for insert and scalar modes |
| wr_lane | input | 2 | Lane index for insert mode |
| wr_data | input | 128 | Write data |
| wr_err | output | 1 | Write rejected for bad lane, size or mode |

## Verification
Read data and both error flags are combinational. They are checked one time unit after the inputs change, with no clock edge in between. A write is due exactly one rising edge after it is presented. The bench therefore presents each write at a falling edge and reads the register back just after the next rising edge. The same-cycle case is checked before that edge, where the old contents must still appear. A rejected write is checked in two places: the flag is sampled before the edge, and the untouched register is read after it.

// File: rtl/vreg_bank.sv
module vreg_bank #(
  parameter int NREG = 32,
  parameter int QW   = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREG)-1:0]  ra_idx,
  input  logic [1:0]               ra_size,
  input  logic [1:0]               ra_lane,
  output logic [QW-1:0]            ra_data,
  output logic                     ra_err,
  input  logic [$clog2(NREG)-1:0]  rb_idx,
  input  logic [1:0]               rb_size,
  input  logic [1:0]               rb_lane,
  output logic [QW-1:0]            rb_data,
  output logic                     rb_err,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [1:0]               wr_mode,
  input  logic [1:0]               wr_size,
  input  logic [1:0]               wr_lane,
  input  logic [QW-1:0]            wr_data,
  output logic                     wr_err
);
  localparam int DW = QW / 2;
  localparam int WW = QW / 4;

  logic [QW-1:0] regs [NREG];
  logic [QW-1:0] cur, nxt;

  function automatic logic rd_bad(input logic [1:0] sz, input logic [1:0] ln);
    return (sz == 2'b11) || (sz == 2'b01 && ln[1]);
  endfunction

  function automatic logic [QW-1:0] rd_view(input logic [QW-1:0] r,
                                            input logic [1:0] sz,
                                            input logic [1:0] ln);
    logic [QW-1:0] v;
    v = '0;
    if (!rd_bad(sz, ln)) begin
      case (sz)
        2'b00:   v[WW-1:0] = r[ln*WW +: WW];
        2'b01:   v[DW-1:0] = r[ln[0]*DW +: DW];
        default: v = r;
      endcase
    end
    return v;
  endfunction

  assign ra_err  = rd_bad(ra_size, ra_lane);
  assign rb_err  = rd_bad(rb_size, rb_lane);
  assign ra_data = rd_view(regs[ra_idx], ra_size, ra_lane);
  assign rb_data = rd_view(regs[rb_idx], rb_size, rb_lane);

  assign wr_err = we && ((wr_mode == 2'b11) ||
                         (wr_mode != 2'b00 && wr_size[1]) ||
                         (wr_mode == 2'b01 && wr_size == 2'b01 && wr_lane[1]));

  assign cur = regs[wr_idx];

  always_comb begin
    nxt = cur;
    case (wr_mode)
      2'b00: nxt = wr_data;
      2'b01: begin
        if (wr_size == 2'b00) nxt[wr_lane*WW +: WW] = wr_data[WW-1:0];
        else                  nxt[wr_lane[0]*DW +: DW] = wr_data[DW-1:0];
      end
      2'b10: begin
        nxt = '0;
        if (wr_size == 2'b00) nxt[WW-1:0] = wr_data[WW-1:0];
        else                  nxt[DW-1:0] = wr_data[DW-1:0];
      end
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && !wr_err) begin
      regs[wr_idx] <= nxt;
    end
  end
endmodule

// File: rtl/vreg_bank_chk.sv
module vreg_bank_chk #(
  parameter int NREG = 32,
  parameter int QW   = 128
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    we,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [1:0]              wr_mode,
  input logic [1:0]              wr_size,
  input logic [1:0]              wr_lane,
  input logic [QW-1:0]           wr_data,
  input logic                    wr_err,
  input logic [1:0]              ra_size,
  input logic [1:0]              ra_lane,
  input logic [QW-1:0]           ra_data,
  input logic                    ra_err,
  input logic [QW-1:0]           regs [NREG]
);
  localparam int DW = QW / 2;

  // R2
  quad_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_err && wr_mode == 2'b00) |=> (regs[$past(wr_idx)] == $past(wr_data)));

  // R5
  lane64_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_err && wr_mode == 2'b01 && wr_size == 2'b01 && !wr_lane[0])
    |=> (regs[$past(wr_idx)][QW-1:DW] == $past(regs[wr_idx][QW-1:DW])));

  // R7
  scalar64_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_err && wr_mode == 2'b10 && wr_size == 2'b01)
    |=> (regs[$past(wr_idx)] == {{(QW-DW){1'b0}}, $past(wr_data[DW-1:0])}));

  // R9
  rejected_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_err) |=> (regs[$past(wr_idx)] == $past(regs[wr_idx])));

  // R10
  read_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ra_err |-> (ra_data == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (rst && !$isunknown(rst)) |=> (regs[0] == '0 && regs[NREG-1] == '0));
endmodule

bind vreg_bank vreg_bank_chk #(.NREG(NREG), .QW(QW)) u_chk (
  .clk(clk), .rst(rst), .we(we), .wr_idx(wr_idx), .wr_mode(wr_mode),
  .wr_size(wr_size), .wr_lane(wr_lane), .wr_data(wr_data), .wr_err(wr_err),
  .ra_size(ra_size), .ra_lane(ra_lane), .ra_data(ra_data), .ra_err(ra_err),
  .regs(regs)
);

// File: tb/vreg_bank_test.sv
`timescale 1ns/1ps
module vreg_bank_test;
  logic clk = 0, rst = 1;
  logic [4:0] ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [1:0] ra_size = 2'b10, ra_lane = 0, rb_size = 2'b10, rb_lane = 0;
  logic [1:0] wr_mode = 0, wr_size = 0, wr_lane = 0;
  logic [127:0] ra_data, rb_data, wr_data = 0;
  logic ra_err, rb_err, wr_err, we = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  vreg_bank uut (.*);

  typedef struct packed {
    logic        en;
    logic [1:0]  mode;
    logic [1:0]  wsz;
    logic [1:0]  wln;
    logic [4:0]  idx;
    logic [127:0] wd;
    logic [1:0]  rsz;
    logic [1:0]  rln;
    logic [127:0] exp;
  } vec_t;

  localparam logic [127:0] Q1 = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] ONES = '1;

  localparam vec_t TBL [9] = '{
    // R2 quad write
    '{1'b1, 2'b00, 2'b00, 2'd0, 5'd3, Q1, 2'b10, 2'd0, Q1},
    // R6 insert word 2
    '{1'b1, 2'b01, 2'b00, 2'd2, 5'd3, 128'hDEADBEEF, 2'b10, 2'd0,
      128'h00112233_DEADBEEF_8899AABB_CCDDEEFF},
    // R5 insert 64-bit lane 0
    '{1'b1, 2'b01, 2'b01, 2'd0, 5'd3, 128'h11223344_55667788, 2'b10, 2'd0,
      128'h00112233_DEADBEEF_11223344_55667788},
    // R3 read 64-bit lane 1
    '{1'b0, 2'b00, 2'b00, 2'd0, 5'd3, 128'h0, 2'b01, 2'd1, 128'h00112233_DEADBEEF},
    // R4 read word 3
    '{1'b0, 2'b00, 2'b00, 2'd0, 5'd3, 128'h0, 2'b00, 2'd3, 128'h00112233},
    // R4 read word 1
    '{1'b0, 2'b00, 2'b00, 2'd0, 5'd3, 128'h0, 2'b00, 2'd1, 128'h11223344},
    // R7 scalar 64 with stray lane index
    '{1'b1, 2'b10, 2'b01, 2'd1, 5'd3, ONES, 2'b10, 2'd0, {64'h0, 64'hFFFFFFFF_FFFFFFFF}},
    // R2 quad write to last register
    '{1'b1, 2'b00, 2'b00, 2'd0, 5'd31, Q1, 2'b10, 2'd0, Q1},
    // R8 scalar 32
    '{1'b1, 2'b10, 2'b00, 2'd0, 5'd31, ONES, 2'b10, 2'd0, {96'h0, 32'hFFFFFFFF}}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [1:0] m, input logic [1:0] s,
                    input logic [1:0] l, input logic [127:0] d);
    @(negedge clk);
    we = 1; wr_idx = i; wr_mode = m; wr_size = s; wr_lane = l; wr_data = d;
    @(posedge clk);
    #1 we = 0;
  endtask

  task automatic rd(input logic [4:0] i, input logic [1:0] s, input logic [1:0] l);
    ra_idx = i; ra_size = s; ra_lane = l;
    #1;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    rd(0, 2'b10, 0);  check("R1 reg0 after reset", ra_data, 0);
    rd(31, 2'b10, 0); check("R1 reg31 after reset", ra_data, 0);

    foreach (TBL[k]) begin
      if (TBL[k].en) wr(TBL[k].idx, TBL[k].mode, TBL[k].wsz, TBL[k].wln, TBL[k].wd);
      else @(negedge clk);
      rd(TBL[k].idx, TBL[k].rsz, TBL[k].rln);
      check($sformatf("table entry %0d", k), ra_data, TBL[k].exp);
    end

    // R2 same-cycle read sees old value
    @(negedge clk);
    we = 1; wr_idx = 5; wr_mode = 2'b00; wr_data = Q1;
    rd(5, 2'b10, 0);
    check("R2 same-cycle old value", ra_data, 0);
    @(posedge clk); #1 we = 0;
    check("R2 value after edge", ra_data, Q1);

    // R11 independent read ports
    @(negedge clk);
    rb_idx = 31; rb_size = 2'b00; rb_lane = 0;
    rd(5, 2'b01, 1);
    check("R11 port A", ra_data, 128'h00112233_44556677);
    check("R11 port B", rb_data, 128'hFFFFFFFF);

    // R9 rejected writes
    @(negedge clk);
    we = 1; wr_idx = 5; wr_mode = 2'b01; wr_size = 2'b01; wr_lane = 2'd2; wr_data = ONES;
    #1 check("R9 flag bad 64 lane", {127'h0, wr_err}, 1);
    @(posedge clk); #1 we = 0;
    rd(5, 2'b10, 0); check("R9 reg unchanged lane", ra_data, Q1);
    @(negedge clk);
    we = 1; wr_mode = 2'b11;
    #1 check("R9 flag reserved mode", {127'h0, wr_err}, 1);
    @(posedge clk); #1 we = 0;
    rd(5, 2'b10, 0); check("R9 reg unchanged mode", ra_data, Q1);
    @(negedge clk);
    we = 1; wr_mode = 2'b10; wr_size = 2'b10;
    #1 check("R9 flag scalar size", {127'h0, wr_err}, 1);
    @(posedge clk); #1 we = 0;
    rd(5, 2'b10, 0); check("R9 reg unchanged size", ra_data, Q1);

    // R10 read errors
    @(negedge clk);
    rd(5, 2'b01, 3);
    check("R10 err 64 lane", {127'h0, ra_err}, 1);
    check("R10 zero data", ra_data, 0);
    rd(5, 2'b11, 0);
    check("R10 err size", {127'h0, ra_err}, 1);
    rd(5, 2'b00, 3);
    check("R10 no err word 3", {127'h0, ra_err}, 0);

    // R1 reset clears written registers
    @(negedge clk) rst = 1;
    @(posedge clk); #1 rst = 0;
    rd(5, 2'b10, 0); check("R1 reg5 cleared", ra_data, 0);
    rd(3, 2'b10, 0); check("R1 reg3 cleared", ra_data, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule